// File: doc/BRIEF.md
# Receive Segment Address Translator

This block sits on the receive side of a chip-to-chip link. Each incoming 32-bit link address carries, in its upper bits, a segment index, a privilege index and optionally a security flag, packed there by the sender. The translator picks those fields out, looks the segment up in a 64-entry table that gives a 16-bit base and a size code, and rebuilds a local address. The local address is the base placed in the upper half-word plus the incoming address masked to the segment size. A separate 16-entry table turns the privilege index into a 4-bit privilege ID.

A configuration port reaches one selector register and two index/value register pairs, one pair per table. The selector register decides which address bits feed each table index and where the security flag sits. The index fields may overlap, so tables are often filled with repeated rows. An entry whose size code marks it empty gives an access error and no valid output. The result is registered one cycle after the input is accepted. The output stage is a three-state machine: IDLE (nothing to present), XLAT (translated address on the outputs) and FAULT (empty segment hit, error shown). From any state, when `out_ready` is high, the next state is IDLE if no input is valid, FAULT if the input hits an empty segment, and XLAT otherwise. While `out_ready` is low the state and the output data hold.

Top module: `rx_seg_xlate`

## Requirements
- R1: After reset every output and every register reads zero, and every segment entry is empty. The selector register (config address 0) keeps the segment select in bits 3:0, the privilege select in bits 11:8, the security select in bits 19:16 and two security-control bits in 25:24, and it reads back exactly those fields.
- R2: Tables are filled by index/value pairs. Writing config address 1 sets the privilege index (bits 3:0) and writing address 2 stores bits 3:0 at that index. Writing address 3 sets the segment index (bits 5:0) and writing address 4 stores base in bits 15:0 and size code in bits 20:16. Reading address 2 or 4 returns the entry at the current index.
- R3: Bit k of the segment index comes from address bit (segsel+16+k), for k from 0 to 5. Positions above 31 read as zero, and a segsel of 0 gives index 0. So segsel 6 selects bits 27:22, 8 selects 29:24 and 12 selects 31:28.
- R4: For size code L of 8 or more, the offset mask is 2^(L+1)-1. The output address is (base<<16) + (address AND mask), modulo 2^32: code 8 is 512 B, 21 is 4 MB and 27 is 256 MB.
- R5: Bit k of the privilege index comes from address bit (privsel+16+k), for k from 0 to 3, with the same zero rules as R3. The 4-bit entry read from the privilege table appears on `out_priv`.
- R6: `out_sec` is address bit (secsel+15) when secsel is nonzero, and 0 when secsel is zero.
- R7: A size code below 8 marks the segment empty. Such an input raises `out_err` and leaves `out_valid` low.
- R8: An input accepted while `out_ready` is high appears on the outputs after the next clock edge. `in_ready` equals `out_ready`. While `out_ready` is low, the outputs hold their values.
- R9: An accepting cycle with `in_valid` low leaves both `out_valid` and `out_err` low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0 to 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr`, combinational |
| in_valid | input | 1 | Incoming address is valid |
| in_ready | output | 1 | Translator accepts input (equals `out_ready`) |
| in_addr | input | 32 | Incoming link address |
| out_valid | output | 1 | Translated result is valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_addr | output | 32 | Rebuilt local address |
| out_priv | output | 4 | Privilege ID |
| out_sec | output | 1 | Security flag |
| out_err | output | 1 | Access hit an empty segment |

## Verification
The translated address, privilege ID, security flag, valid and error are each due one clock edge after the input is presented with `out_ready` high. The bench drives inputs on the falling edge and compares all five outputs on the following falling edge, after exactly one rising edge. Configuration readback is combinational, so after a write the bench waits one rising edge and then compares `cfg_rdata` half a cycle later. In the stall test the bench holds `out_ready` low across an edge and checks that the earlier result is still on the outputs and that `in_ready` is low.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int ADDR_W     = 32;
    localparam int BASE_W     = 16;
    localparam int LEN_W      = 5;
    localparam int SEL_W      = 4;
    localparam int FIELD_BASE = 16;
    localparam int MIN_LEN    = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XLAT  = 2'd1,
        ST_FAULT = 2'd2
    } ostate_e;

    typedef enum logic [2:0] {
        CR_SELECT   = 3'd0,
        CR_PRIV_IDX = 3'd1,
        CR_PRIV_VAL = 3'd2,
        CR_SEG_IDX  = 3'd3,
        CR_SEG_VAL  = 3'd4
    } cfg_reg_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } seg_entry_t;

    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        return ~({{(ADDR_W-1){1'b1}}, 1'b0} << len);
    endfunction
endpackage

// File: rtl/rxs_bitpick.sv
module rxs_bitpick #(
    parameter int IDX_W    = 6,
    parameter int BASE_BIT = 16
) (
    input  logic [31:0]      addr,
    input  logic [3:0]       sel,
    output logic [IDX_W-1:0] idx
);
    for (genvar k = 0; k < IDX_W; k++) begin : g_bit
        logic [6:0] pos;
        assign pos    = 7'(sel) + 7'(BASE_BIT + k);
        assign idx[k] = ((sel != 4'd0) && (pos < 7'd32)) ? addr[pos[4:0]] : 1'b0;
    end
endmodule

// File: rtl/rxs_regfile.sv
module rxs_regfile
    import rxs_pkg::*;
#(
    parameter int SEG_IDX_W  = 6,
    parameter int PRIV_IDX_W = 4,
    parameter int PRIV_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    output logic [SEL_W-1:0]      seg_sel,
    output logic [SEL_W-1:0]      priv_sel,
    output logic [SEL_W-1:0]      sec_sel,
    input  logic [SEG_IDX_W-1:0]  seg_lk_idx,
    output seg_entry_t            seg_lk,
    input  logic [PRIV_IDX_W-1:0] priv_lk_idx,
    output logic [PRIV_W-1:0]     priv_lk
);
    localparam int SEG_N  = 1 << SEG_IDX_W;
    localparam int PRIV_N = 1 << PRIV_IDX_W;

    logic [1:0]            sec_ctl;
    logic [SEG_IDX_W-1:0]  seg_ptr;
    logic [PRIV_IDX_W-1:0] priv_ptr;
    seg_entry_t            seg_tab  [SEG_N];
    logic [PRIV_W-1:0]     priv_tab [PRIV_N];
    logic                  unused_wdata;

    assign unused_wdata = ^cfg_wdata[31:26];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_sel  <= '0;
            priv_sel <= '0;
            sec_sel  <= '0;
            sec_ctl  <= '0;
            seg_ptr  <= '0;
            priv_ptr <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                CR_SELECT: begin
                    seg_sel  <= cfg_wdata[3:0];
                    priv_sel <= cfg_wdata[11:8];
                    sec_sel  <= cfg_wdata[19:16];
                    sec_ctl  <= cfg_wdata[25:24];
                end
                CR_PRIV_IDX: priv_ptr <= cfg_wdata[PRIV_IDX_W-1:0];
                CR_SEG_IDX:  seg_ptr  <= cfg_wdata[SEG_IDX_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                seg_tab[s] <= '0;
            else if (cfg_we && cfg_addr == CR_SEG_VAL && seg_ptr == SEG_IDX_W'(s))
                seg_tab[s] <= '{base: cfg_wdata[15:0], len: cfg_wdata[20:16]};
        end
    end

    for (genvar p = 0; p < PRIV_N; p++) begin : g_priv
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                priv_tab[p] <= '0;
            else if (cfg_we && cfg_addr == CR_PRIV_VAL && priv_ptr == PRIV_IDX_W'(p))
                priv_tab[p] <= cfg_wdata[PRIV_W-1:0];
        end
    end

    assign seg_lk  = seg_tab[seg_lk_idx];
    assign priv_lk = priv_tab[priv_lk_idx];

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            CR_SELECT: begin
                cfg_rdata[3:0]   = seg_sel;
                cfg_rdata[11:8]  = priv_sel;
                cfg_rdata[19:16] = sec_sel;
                cfg_rdata[25:24] = sec_ctl;
            end
            CR_PRIV_IDX: cfg_rdata[PRIV_IDX_W-1:0] = priv_ptr;
            CR_PRIV_VAL: cfg_rdata[PRIV_W-1:0]     = priv_tab[priv_ptr];
            CR_SEG_IDX:  cfg_rdata[SEG_IDX_W-1:0]  = seg_ptr;
            CR_SEG_VAL: begin
                cfg_rdata[15:0]  = seg_tab[seg_ptr].base;
                cfg_rdata[20:16] = seg_tab[seg_ptr].len;
            end
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxs_out_stage.sv
module rxs_out_stage
    import rxs_pkg::*;
#(
    parameter int PRIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic              fault,
    input  logic [31:0]       x_addr,
    input  logic [PRIV_W-1:0] x_priv,
    input  logic              x_sec,
    output logic              out_valid,
    output logic              out_err,
    output logic [31:0]       out_addr,
    output logic [PRIV_W-1:0] out_priv,
    output logic              out_sec
);
    ostate_e state, nxt;

    always_comb begin
        if (!in_valid)   nxt = ST_IDLE;
        else if (fault)  nxt = ST_FAULT;
        else             nxt = ST_XLAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (out_ready)
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_priv <= '0;
            out_sec  <= 1'b0;
        end else if (out_ready && in_valid) begin
            out_addr <= x_addr;
            out_priv <= x_priv;
            out_sec  <= x_sec;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  begin out_valid = 1'b0; out_err = 1'b0; end
            ST_XLAT:  begin out_valid = 1'b1; out_err = 1'b0; end
            ST_FAULT: begin out_valid = 1'b0; out_err = 1'b1; end
            default:  begin out_valid = 1'b0; out_err = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rx_seg_xlate.sv
module rx_seg_xlate
    import rxs_pkg::*;
#(
    parameter int SEG_IDX_W  = 6,
    parameter int PRIV_IDX_W = 4,
    parameter int PRIV_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_addr,
    output logic [PRIV_W-1:0] out_priv,
    output logic              out_sec,
    output logic              out_err
);
    logic [SEL_W-1:0]      seg_sel, priv_sel, sec_sel;
    logic [SEG_IDX_W-1:0]  seg_idx;
    logic [PRIV_IDX_W-1:0] priv_idx;
    seg_entry_t            seg_e;
    logic [PRIV_W-1:0]     priv_v;
    logic [4:0]            sec_pos;
    logic                  x_sec, fault;
    logic [31:0]           x_addr;

    rxs_regfile #(
        .SEG_IDX_W (SEG_IDX_W),
        .PRIV_IDX_W(PRIV_IDX_W),
        .PRIV_W    (PRIV_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .seg_sel    (seg_sel),
        .priv_sel   (priv_sel),
        .sec_sel    (sec_sel),
        .seg_lk_idx (seg_idx),
        .seg_lk     (seg_e),
        .priv_lk_idx(priv_idx),
        .priv_lk    (priv_v)
    );

    rxs_bitpick #(.IDX_W(SEG_IDX_W), .BASE_BIT(FIELD_BASE)) u_seg_pick (
        .addr(in_addr), .sel(seg_sel), .idx(seg_idx)
    );

    rxs_bitpick #(.IDX_W(PRIV_IDX_W), .BASE_BIT(FIELD_BASE)) u_priv_pick (
        .addr(in_addr), .sel(priv_sel), .idx(priv_idx)
    );

    assign sec_pos = 5'(sec_sel) + 5'(FIELD_BASE - 1);
    assign x_sec   = (sec_sel != '0) ? in_addr[sec_pos] : 1'b0;
    assign fault   = (seg_e.len < LEN_W'(MIN_LEN));
    assign x_addr  = {seg_e.base, 16'h0000} + (in_addr & len_mask(seg_e.len));
    assign in_ready = out_ready;

    rxs_out_stage #(.PRIV_W(PRIV_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .fault    (fault),
        .x_addr   (x_addr),
        .x_priv   (priv_v),
        .x_sec    (x_sec),
        .out_valid(out_valid),
        .out_err  (out_err),
        .out_addr (out_addr),
        .out_priv (out_priv),
        .out_sec  (out_sec)
    );
endmodule

// File: rtl/rxs_sva.sv
module rxs_sva #(
    parameter int PRIV_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_err,
    input logic [31:0]       out_addr,
    input logic [PRIV_W-1:0] out_priv,
    input logic              out_sec
);
    // R7: an error result never also claims valid
    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));

    // R8: a stalled result holds its address, privilege and flag
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_priv) && $stable(out_sec)));

    // R8: an accepted input yields a result after one edge
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid || out_err));

    // R9: an accepting cycle without input leaves the outputs quiet
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_ready) |=> (!out_valid && !out_err));

    // R8: an error result also holds while stalled
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err && !out_ready) |=> out_err);
endmodule

bind rx_seg_xlate rxs_sva #(.PRIV_W(PRIV_W)) u_rxs_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_err  (out_err),
    .out_addr (out_addr),
    .out_priv (out_priv),
    .out_sec  (out_sec)
);

// File: tb/test_rx_seg_xlate.sv
module test_rx_seg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [3:0]  out_priv;
    logic        out_sec;
    logic        out_err;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [15:0] m_base [64];
    logic [4:0]  m_len  [64];
    logic [3:0]  m_priv [16];
    logic [3:0]  m_segsel, m_privsel, m_secsel;

    always #5 clk = ~clk;

    rx_seg_xlate i_rx_seg_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_priv(out_priv),
        .out_sec(out_sec), .out_err(out_err)
    );

    function automatic int pick(input logic [31:0] a, input logic [3:0] sel, input int w);
        int r = 0;
        if (sel == 0) return 0;
        for (int k = 0; k < w; k++)
            if (int'(sel) + 16 + k <= 31 && a[int'(sel) + 16 + k]) r += (1 << k);
        return r;
    endfunction

    function automatic logic [31:0] mask_of(input logic [4:0] len);
        logic [32:0] m = (33'd1 << (int'(len) + 1)) - 33'd1;
        return m[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_sel(input logic [3:0] sg, input logic [3:0] pv, input logic [3:0] sc);
        m_segsel = sg; m_privsel = pv; m_secsel = sc;
        cfg_wr(3'd0, {8'h0, 4'h0, sc, 4'h0, pv, 4'h0, sg});
    endtask

    task automatic put_seg(input int i, input logic [15:0] b, input logic [4:0] l);
        m_base[i] = b; m_len[i] = l;
        cfg_wr(3'd3, 32'(i));
        cfg_wr(3'd4, {11'h0, l, b});
    endtask

    task automatic put_priv(input int i, input logic [3:0] v);
        m_priv[i] = v;
        cfg_wr(3'd1, 32'(i));
        cfg_wr(3'd2, {28'h0, v});
    endtask

    // drive one address, check outputs one edge later
    task automatic xlate(input logic [31:0] a);
        int si, pi;
        logic [31:0] ea;
        logic es;
        bit empty;
        si = pick(a, m_segsel, 6);
        pi = pick(a, m_privsel, 4);
        empty = m_len[si] < 5'd8;
        ea = {m_base[si], 16'h0} + (a & mask_of(m_len[si]));
        es = (m_secsel != 0) ? a[int'(m_secsel) + 15] : 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 valid", {31'h0, out_valid}, {31'h0, !empty});
        check("R7 err", {31'h0, out_err}, {31'h0, empty});
        if (!empty) begin
            check("R3/R4 addr", out_addr, ea);
            check("R5 priv", {28'h0, out_priv}, {28'h0, m_priv[pi]});
            check("R6 sec", {31'h0, out_sec}, {31'h0, es});
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_addr;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) begin m_base[i] = '0; m_len[i] = '0; end
        for (int i = 0; i < 16; i++) m_priv[i] = '0;
        m_segsel = '0; m_privsel = '0; m_secsel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 out_valid", {31'h0, out_valid}, 32'h0);
        check("R1 out_err", {31'h0, out_err}, 32'h0);
        check("R1 out_addr", out_addr, 32'h0);
        cfg_addr = 3'd0; #1;
        check("R1 selector", cfg_rdata, 32'h0);
        cfg_addr = 3'd4; #1;
        check("R1 seg entry", cfg_rdata, 32'h0);

        // R1: selector readback with security-control bits
        cfg_wr(3'd0, 32'hFFFF_FFFF);
        cfg_addr = 3'd0; #1;
        check("R1 selector fields", cfg_rdata, 32'h030F_0F0F);

        // R9: empty table entry at index 0 gives an error, idle gives nothing
        set_sel(4'd0, 4'd0, 4'd0);
        xlate(32'h1234_5678);
        @(negedge clk);
        check("R9 idle valid", {31'h0, out_valid}, 32'h0);
        check("R9 idle err", {31'h0, out_err}, 32'h0);

        // R2: table programming and readback
        put_seg(37, 16'hBEEF, 5'd19);
        put_priv(9, 4'hA);
        cfg_wr(3'd3, 32'd37);
        cfg_addr = 3'd4; #1;
        check("R2 seg readback", cfg_rdata, 32'h0013_BEEF);
        cfg_addr = 3'd3; #1;
        check("R2 seg index", cfg_rdata, 32'd37);
        cfg_wr(3'd1, 32'd9);
        cfg_addr = 3'd2; #1;
        check("R2 priv readback", cfg_rdata, 32'hA);

        // R4/R5: one 256 MB segment on every index, privilege by upper nibble
        for (int i = 0; i < 64; i++) put_seg(i, 16'h8000, 5'd27);
        for (int i = 0; i < 16; i++) put_priv(i, (i < 8) ? 4'hD : 4'hE);
        set_sel(4'd12, 4'd12, 4'd0);
        xlate(32'h5567_89A0);
        check("R4 example 256MB", out_addr, 32'h8567_89A0);
        check("R5 example priv", {28'h0, out_priv}, 32'hD);

        // R3: 16 MB segments indexed by bits 29:24
        put_seg(53, 16'h8A00, 5'd23);
        set_sel(4'd8, 4'd12, 4'd0);
        xlate(32'h7567_89A0);
        check("R3 example index 53", out_addr, 32'h8A67_89A0);

        // R4: smallest segment size, R7: code 7 is empty
        put_seg(0, 16'h1234, 5'd8);
        set_sel(4'd0, 4'd0, 4'd1);
        xlate(32'hFFFF_FFFF);
        check("R4 512B mask", out_addr, 32'h1234_01FF);
        put_seg(0, 16'h1234, 5'd7);
        xlate(32'h0000_0010);

        // R8: stall holds the previous result and drops in_ready
        put_seg(0, 16'h4000, 5'd15);
        xlate(32'h0000_0ABC);
        hold_addr = out_addr;
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0000_0123;
        #1;
        check("R8 in_ready", {31'h0, in_ready}, 32'h0);
        @(negedge clk);
        check("R8 hold addr", out_addr, hold_addr);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 after release", out_addr, 32'h4000_0123);

        // random tables, selectors and addresses
        for (int i = 0; i < 64; i++) put_seg(i, 16'($urandom), 5'($urandom));
        for (int i = 0; i < 16; i++) put_priv(i, 4'($urandom));
        for (int n = 0; n < 400; n++) begin
            if (n % 25 == 0)
                set_sel(4'($urandom), 4'($urandom), 4'($urandom));
            xlate($urandom);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule